// File: doc/BRIEF.md
# Bank Command Responder with Shared Data Scheduler

This block stands in for a set of DRAM bank machines so that logic upstream of them (an arbiter or crossbar) can be exercised against a realistic command and data handshake without any DRAM timing model. Each bank holds one command in a single buffer, with no queue. It raises a lock while that command is pending. After a fixed processing delay it competes for one shared data path. When it wins, it pulses either a write-data-ready or a read-data-valid strobe for one cycle.

A shared scheduler then times the data. A write's data word and byte enables are sampled a fixed number of cycles after the strobe and logged together with the bank and address. A read's return word is driven a fixed number of cycles after the strobe, taken from a counter that starts at 0x10 and steps once per read. A clash flag reports two same-kind transfers falling in one cycle.

The command side is a valid/ready interface per bank. The master raises valid with the address and write flag and must hold all three until the edge where ready is high. Ready is a one-cycle pulse that comes one cycle after valid is first seen by an idle bank. Valid seen while the bank is busy is left waiting, which is the only back-pressure. The data side has no back-pressure: the strobes and returns are fixed-latency events.

Top module: `bank_resp_top`

## Requirements
- R1: While a bank is idle its lock equals its command valid input; from the cycle after valid is first seen up to and including its transfer strobe cycle the lock stays high, and it falls only in the cycle after that strobe.
- R2: An idle bank that sees valid at a clock edge raises cmd_ready in the next cycle for exactly one cycle, and the address and write flag are the values present at that first edge, even if the master changes the address during the ready cycle.
- R3: With the data path free, a bank's strobe comes CMD_DELAY+2 cycles after its ready cycle (8 cycles with the default delay of 6).
- R4: At most one bank strobes per cycle; among banks waiting together the lowest bank index wins, and each following waiting bank strobes two cycles after the previous one.
- R5: A write gives exactly one wdata_ready cycle T; wdata and wdata_be are sampled in cycle T+WR_LAT and shown on the write log outputs (valid, bank, address, data, enables) in cycle T+WR_LAT+1.
- R6: A read gives exactly one rdata_valid cycle T; in cycle T+RD_LAT rd_ret_valid is high with rdata, the bank and the address.
- R7: Read data is 0x10 for the first read after reset and rises by one for every read returned, in return order, across all banks.
- R8: sched_err goes high in the cycle after two write strobes or two read strobes occur in the same cycle; under legal operation it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | NB | Per-bank command valid |
| cmd_we | input | NB | Per-bank write flag (1 = write, 0 = read) |
| cmd_addr | input | NB*AW | Per-bank address, bank i in bits [i*AW +: AW] |
| cmd_ready | output | NB | Per-bank one-cycle accept pulse |
| lock | output | NB | Per-bank command-pending lock |
| wdata_ready | output | NB | Per-bank write strobe |
| rdata_valid | output | NB | Per-bank read strobe |
| wdata | input | DW | Shared write data |
| wdata_be | input | DW/8 | Shared write byte enables |
| wr_log_valid | output | 1 | Write capture logged |
| wr_log_bank | output | log2(NB) | Bank of the logged write |
| wr_log_addr | output | AW | Address of the logged write |
| wr_log_data | output | DW | Captured write data |
| wr_log_be | output | DW/8 | Captured byte enables |
| rd_ret_valid | output | 1 | Read data on rdata this cycle |
| rd_ret_bank | output | log2(NB) | Bank of the returned read |
| rd_ret_addr | output | AW | Address of the returned read |
| rdata | output | DW | Returned read data |
| sched_err | output | 1 | Same-kind transfer clash flag |

## Verification
Each result has a due cycle counted from the cycle c in which the bench raises valid. Ready is due at c+1. The strobe of the j-th waiting bank in index order is due at c+9+2j. A write log entry is due one cycle after the strobe plus WR_LAT, carrying the wdata the bench drove in the strobe cycle plus WR_LAT, since the bench drives wdata with the cycle number. A read return is due at the strobe plus RD_LAT. The bench samples every output at the falling edge, records the cycle of each event, and compares it with these arithmetic due cycles. It sweeps every nonempty bank set with two write/read patterns.

// File: rtl/bank_resp_pkg.sv
package bank_resp_pkg;
  typedef enum logic [2:0] {
    B_IDLE = 3'd0,
    B_ACK  = 3'd1,
    B_WAIT = 3'd2,
    B_ARB  = 3'd3,
    B_XFER = 3'd4
  } bank_st_e;
endpackage

// File: rtl/bank_unit.sv
module bank_unit
  import bank_resp_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DELAY = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  output logic          lock,
  input  logic          gnt,
  output logic          req,
  output logic          xfer,
  output logic          wr_pulse,
  output logic          rd_pulse,
  output logic [AW-1:0] addr_q
);
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;

  bank_st_e      st;
  logic          we_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= B_IDLE;
      we_q   <= 1'b0;
      addr_q <= '0;
      cnt    <= '0;
    end else begin
      case (st)
        B_IDLE: if (cmd_valid) begin
          addr_q <= cmd_addr;
          we_q   <= cmd_we;
          st     <= B_ACK;
        end
        B_ACK: begin
          cnt <= '0;
          st  <= B_WAIT;
        end
        B_WAIT: begin
          if (cnt == CW'(DELAY - 1)) st <= B_ARB;
          else cnt <= cnt + 1'b1;
        end
        B_ARB:  if (gnt) st <= B_XFER;
        B_XFER: st <= B_IDLE;
        default: st <= B_IDLE;
      endcase
    end
  end

  assign cmd_ready = (st == B_ACK);
  assign lock      = (st != B_IDLE) || cmd_valid;
  assign req       = (st == B_ARB);
  assign xfer      = (st == B_XFER);
  assign wr_pulse  = xfer && we_q;
  assign rd_pulse  = xfer && !we_q;

  p_ready_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> !cmd_ready);
  p_strobe_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !xfer);
  p_lock_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> $past(xfer));
endmodule

// File: rtl/path_arbiter.sv
module path_arbiter #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] req,
  input  logic          busy,
  output logic [NB-1:0] gnt
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < NB; i++) begin
      if (req[i] && !found && !busy) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_grant_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  p_no_grant_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (gnt == '0));
endmodule

// File: rtl/xfer_pipe.sv
module xfer_pipe #(
  parameter int          NB      = 4,
  parameter int          AW      = 8,
  parameter int          DW      = 16,
  parameter int          WR_LAT  = 1,
  parameter int          RD_LAT  = 5,
  parameter logic [15:0] RD_SEED = 16'h0010,
  localparam int         BW      = (NB > 1) ? $clog2(NB) : 1,
  localparam int         BEW     = DW / 8,
  localparam int         RDEP    = RD_LAT - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_go,
  input  logic           rd_go,
  input  logic [BW-1:0]  go_bank,
  input  logic [AW-1:0]  go_addr,
  input  logic           clash,
  input  logic [DW-1:0]  wdata,
  input  logic [BEW-1:0] wdata_be,
  output logic           wr_log_valid,
  output logic [BW-1:0]  wr_log_bank,
  output logic [AW-1:0]  wr_log_addr,
  output logic [DW-1:0]  wr_log_data,
  output logic [BEW-1:0] wr_log_be,
  output logic           rd_ret_valid,
  output logic [BW-1:0]  rd_ret_bank,
  output logic [AW-1:0]  rd_ret_addr,
  output logic [DW-1:0]  rdata,
  output logic           sched_err
);
  logic [WR_LAT-1:0] wv;
  logic [BW-1:0]     wb [WR_LAT];
  logic [AW-1:0]     wa [WR_LAT];
  logic [RDEP-1:0]   rv;
  logic [BW-1:0]     rb [RDEP];
  logic [AW-1:0]     ra [RDEP];
  logic [DW-1:0]     rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wv[0] <= 1'b0;
      rv[0] <= 1'b0;
    end else begin
      wv[0] <= wr_go;
      rv[0] <= rd_go;
    end
    wb[0] <= go_bank;
    wa[0] <= go_addr;
    rb[0] <= go_bank;
    ra[0] <= go_addr;
  end

  for (genvar k = 1; k < WR_LAT; k++) begin : g_wstage
    always_ff @(posedge clk) begin
      if (!rst_n) wv[k] <= 1'b0;
      else wv[k] <= wv[k-1];
      wb[k] <= wb[k-1];
      wa[k] <= wa[k-1];
    end
  end

  for (genvar k = 1; k < RDEP; k++) begin : g_rstage
    always_ff @(posedge clk) begin
      if (!rst_n) rv[k] <= 1'b0;
      else rv[k] <= rv[k-1];
      rb[k] <= rb[k-1];
      ra[k] <= ra[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_log_valid <= 1'b0;
      wr_log_bank  <= '0;
      wr_log_addr  <= '0;
      wr_log_data  <= '0;
      wr_log_be    <= '0;
      rd_ret_valid <= 1'b0;
      rd_ret_bank  <= '0;
      rd_ret_addr  <= '0;
      rdata        <= '0;
      rd_cnt       <= DW'(RD_SEED);
      sched_err    <= 1'b0;
    end else begin
      wr_log_valid <= wv[WR_LAT-1];
      rd_ret_valid <= rv[RDEP-1];
      sched_err    <= clash;
      if (wv[WR_LAT-1]) begin
        wr_log_bank <= wb[WR_LAT-1];
        wr_log_addr <= wa[WR_LAT-1];
        wr_log_data <= wdata;
        wr_log_be   <= wdata_be;
      end
      if (rv[RDEP-1]) begin
        rd_ret_bank <= rb[RDEP-1];
        rd_ret_addr <= ra[RDEP-1];
        rdata       <= rd_cnt;
        rd_cnt      <= rd_cnt + 1'b1;
      end
    end
  end

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ret_valid |-> (rd_cnt == rdata + 1'b1));
  p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sched_err);
endmodule

// File: rtl/bank_resp_top.sv
module bank_resp_top #(
  parameter int          NB        = 4,
  parameter int          AW        = 8,
  parameter int          DW        = 16,
  parameter int          CMD_DELAY = 6,
  parameter int          WR_LAT    = 1,
  parameter int          RD_LAT    = 5,
  parameter logic [15:0] RD_SEED   = 16'h0010,
  localparam int         BW        = (NB > 1) ? $clog2(NB) : 1,
  localparam int         BEW       = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB-1:0]    cmd_valid,
  input  logic [NB-1:0]    cmd_we,
  input  logic [NB*AW-1:0] cmd_addr,
  output logic [NB-1:0]    cmd_ready,
  output logic [NB-1:0]    lock,
  output logic [NB-1:0]    wdata_ready,
  output logic [NB-1:0]    rdata_valid,
  input  logic [DW-1:0]    wdata,
  input  logic [BEW-1:0]   wdata_be,
  output logic             wr_log_valid,
  output logic [BW-1:0]    wr_log_bank,
  output logic [AW-1:0]    wr_log_addr,
  output logic [DW-1:0]    wr_log_data,
  output logic [BEW-1:0]   wr_log_be,
  output logic             rd_ret_valid,
  output logic [BW-1:0]    rd_ret_bank,
  output logic [AW-1:0]    rd_ret_addr,
  output logic [DW-1:0]    rdata,
  output logic             sched_err
);
  logic [NB-1:0] req, gnt, xfer;
  logic [AW-1:0] addr_q [NB];
  logic [BW-1:0] go_bank;
  logic [AW-1:0] go_addr;
  logic          clash;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    bank_unit #(.AW(AW), .DELAY(CMD_DELAY)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_valid(cmd_valid[i]),
      .cmd_we   (cmd_we[i]),
      .cmd_addr (cmd_addr[i*AW +: AW]),
      .cmd_ready(cmd_ready[i]),
      .lock     (lock[i]),
      .gnt      (gnt[i]),
      .req      (req[i]),
      .xfer     (xfer[i]),
      .wr_pulse (wdata_ready[i]),
      .rd_pulse (rdata_valid[i]),
      .addr_q   (addr_q[i])
    );
  end

  path_arbiter #(.NB(NB)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req),
    .busy (|xfer),
    .gnt  (gnt)
  );

  always_comb begin
    go_bank = '0;
    go_addr = '0;
    for (int i = 0; i < NB; i++) begin
      if (xfer[i]) begin
        go_bank = go_bank | BW'(i);
        go_addr = go_addr | addr_q[i];
      end
    end
    clash = ($countones(wdata_ready) > 1) || ($countones(rdata_valid) > 1);
  end

  xfer_pipe #(
    .NB(NB), .AW(AW), .DW(DW), .WR_LAT(WR_LAT), .RD_LAT(RD_LAT), .RD_SEED(RD_SEED)
  ) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_go       (|wdata_ready),
    .rd_go       (|rdata_valid),
    .go_bank     (go_bank),
    .go_addr     (go_addr),
    .clash       (clash),
    .wdata       (wdata),
    .wdata_be    (wdata_be),
    .wr_log_valid(wr_log_valid),
    .wr_log_bank (wr_log_bank),
    .wr_log_addr (wr_log_addr),
    .wr_log_data (wr_log_data),
    .wr_log_be   (wr_log_be),
    .rd_ret_valid(rd_ret_valid),
    .rd_ret_bank (rd_ret_bank),
    .rd_ret_addr (rd_ret_addr),
    .rdata       (rdata),
    .sched_err   (sched_err)
  );

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wdata_ready | rdata_valid));
  p_strobe_kind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_ready & rdata_valid) == '0);
endmodule

// File: tb/sim_bank_resp_top.sv
module sim_bank_resp_top;
  localparam int NB = 4, AW = 8, DW = 16, D = 6, WL = 1, RL = 5;
  localparam int BW = 2, BEW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] cmd_valid = '0, cmd_we = '0;
  logic [NB*AW-1:0] cmd_addr = '0;
  logic [NB-1:0] cmd_ready, lock, wdata_ready, rdata_valid;
  logic [DW-1:0] wdata = '0;
  logic [BEW-1:0] wdata_be = '0;
  logic wr_log_valid, rd_ret_valid, sched_err;
  logic [BW-1:0] wr_log_bank, rd_ret_bank;
  logic [AW-1:0] wr_log_addr, rd_ret_addr;
  logic [DW-1:0] wr_log_data, rdata;
  logic [BEW-1:0] wr_log_be;

  always #2.5 clk = ~clk;

  bank_resp_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_we(cmd_we),
    .cmd_addr(cmd_addr), .cmd_ready(cmd_ready), .lock(lock),
    .wdata_ready(wdata_ready), .rdata_valid(rdata_valid),
    .wdata(wdata), .wdata_be(wdata_be),
    .wr_log_valid(wr_log_valid), .wr_log_bank(wr_log_bank),
    .wr_log_addr(wr_log_addr), .wr_log_data(wr_log_data), .wr_log_be(wr_log_be),
    .rd_ret_valid(rd_ret_valid), .rd_ret_bank(rd_ret_bank),
    .rd_ret_addr(rd_ret_addr), .rdata(rdata), .sched_err(sched_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0, total_reads = 0;
  bit finished = 1'b0;

  int rdy_n [NB], rdy_c [NB], pls_n [NB], pls_c [NB], pls_w [NB];
  bit outst [NB];
  bit lock_bad, err_seen;
  int rl_n, wl_n;
  int rl_c [8], rl_b [8], rl_a [8], rl_d [8];
  int wl_c [8], wl_b [8], wl_a [8], wl_d [8], wl_e [8];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sample();
    for (int b = 0; b < NB; b++) begin
      if (lock[b] !== outst[b]) lock_bad = 1'b1;
      if (cmd_ready[b]) begin rdy_n[b]++; rdy_c[b] = cyc; end
      if (wdata_ready[b] || rdata_valid[b]) begin
        pls_n[b]++; pls_c[b] = cyc; pls_w[b] = wdata_ready[b]; outst[b] = 1'b0;
      end
    end
    if (rd_ret_valid && rl_n < 8) begin
      rl_c[rl_n] = cyc; rl_b[rl_n] = rd_ret_bank; rl_a[rl_n] = rd_ret_addr;
      rl_d[rl_n] = rdata; rl_n++;
    end
    if (wr_log_valid && wl_n < 8) begin
      wl_c[wl_n] = cyc; wl_b[wl_n] = wr_log_bank; wl_a[wl_n] = wr_log_addr;
      wl_d[wl_n] = wr_log_data; wl_e[wl_n] = wr_log_be; wl_n++;
    end
    if (sched_err) err_seen = 1'b1;
  endtask

  task automatic drive_data();
    wdata    = DW'(cyc);
    wdata_be = BEW'(cyc);
  endtask

  task automatic do_run(input logic [NB-1:0] mask, input logic [NB-1:0] wem, input int tag);
    int c, j, ri, wi, p;
    for (int b = 0; b < NB; b++) begin
      rdy_n[b] = 0; pls_n[b] = 0; rdy_c[b] = -1; pls_c[b] = -1; pls_w[b] = 0; outst[b] = 0;
    end
    lock_bad = 0; err_seen = 0; rl_n = 0; wl_n = 0;
    @(negedge clk);
    sample();
    drive_data();
    c = cyc;
    for (int b = 0; b < NB; b++) begin
      if (mask[b]) begin
        cmd_valid[b] = 1'b1; cmd_we[b] = wem[b];
        cmd_addr[b*AW +: AW] = AW'((tag << 2) | b);
        outst[b] = 1'b1;
      end
    end
    #1;
    chk(lock === mask, "R1 idle lock follows valid", lock, mask);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      sample();
      drive_data();
      for (int b = 0; b < NB; b++) begin
        if (cmd_valid[b] && rdy_n[b] > 0) begin
          if (rdy_c[b] == cyc) cmd_addr[b*AW +: AW] = ~cmd_addr[b*AW +: AW];
          else cmd_valid[b] = 1'b0;
        end
      end
    end
    chk(!lock_bad, "R1 lock tracks pending command", lock_bad, 0);
    chk(!err_seen, "R8 no clash flag", err_seen, 0);
    j = 0; ri = 0; wi = 0;
    for (int b = 0; b < NB; b++) begin
      if (mask[b]) begin
        p = c + 9 + 2 * j;
        chk(rdy_n[b] == 1 && rdy_c[b] == c + 1, "R2 ready cycle", rdy_c[b], c + 1);
        chk(pls_n[b] == 1 && pls_c[b] == p, "R3/R4 strobe cycle", pls_c[b], p);
        chk(pls_w[b] == int'(wem[b]), "R5/R6 strobe kind", pls_w[b], wem[b]);
        if (wem[b]) begin
          chk(wi < wl_n && wl_c[wi] == p + WL + 1, "R5 write log cycle", wl_c[wi], p + WL + 1);
          chk(wl_d[wi] == ((p + WL) & 16'hffff) && wl_e[wi] == ((p + WL) & 3),
              "R5 captured data", wl_d[wi], (p + WL) & 16'hffff);
          chk(wl_b[wi] == b && wl_a[wi] == (((tag << 2) | b) & 8'hff),
              "R2 write bank/addr latched", wl_a[wi], ((tag << 2) | b) & 8'hff);
          wi++;
        end else begin
          chk(ri < rl_n && rl_c[ri] == p + RL, "R6 read return cycle", rl_c[ri], p + RL);
          chk(rl_d[ri] == 16 + total_reads, "R7 read data value", rl_d[ri], 16 + total_reads);
          chk(rl_b[ri] == b && rl_a[ri] == (((tag << 2) | b) & 8'hff),
              "R6 read bank/addr", rl_a[ri], ((tag << 2) | b) & 8'hff);
          ri++; total_reads++;
        end
        j++;
      end
    end
    chk(rl_n == ri && wl_n == wi, "R5/R6 event count", rl_n * 16 + wl_n, ri * 16 + wi);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 0 && wdata_ready == 0 && rdata_valid == 0, "R2 reset strobes", cmd_ready, 0);
    chk(lock == 0, "R1 reset lock low", lock, 0);
    chk(!wr_log_valid && !rd_ret_valid && !sched_err, "R8 reset flags",
        {wr_log_valid, rd_ret_valid, sched_err}, 0);
    for (int m = 1; m < 16; m++) begin
      do_run(NB'(m), 4'b0101, m);
      do_run(NB'(m), 4'b1010, m + 16);
    end
    do_run(4'b1111, 4'b1111, 40);
    do_run(4'b1111, 4'b0000, 41);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected finish", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule